// File: doc/BRIEF.md
# Cyclic Spectral Correlation Accumulator

This block estimates the spectral correlation of a signal at one cyclic frequency, set at runtime. It takes frames of FFT bins. Each frame is the N-point transform of N consecutive samples that do not overlap the samples of the previous frame. For every bin index k the block forms the product of bin k with the complex conjugate of the bin `alpha` positions below it. That lower index wraps modulo N. The product is scaled by a programmable smoothing weight W[k] and summed into a per-bin accumulator over a window of 2^E frames.

After the last frame of a window, the block emits the N averaged results in ascending bin order, one per clock. It raises a done pulse alongside the final bin, clears the accumulators and begins the next window on its own. Averaging divides by 2^E as an arithmetic right shift.

Each arriving frame is written into one half of a two-bank buffer. The other half holds the previous complete frame while it is swept. This lets bin k-alpha be read whatever the order in which bins arrived, and it lets frames arrive back to back.

Top module: `scf_corr_acc`

## Requirements
- R1: While reset is asserted and after its release, with no input, `out_valid` and `out_done` are 0.
- R2: Bins arrive in natural order with `in_sof` marking bin 0. For bin k the product is X[k]·conj(X[(k−alpha) mod N]), with both bins taken from the same frame. Its real part is xr·yr + xi·yi and its imaginary part is xi·yr − xr·yi.
- R3: Each product is multiplied by the unsigned window weight W[k]. The weight is written through `win_we`/`win_addr`/`win_data`, and every weight resets to 1.
- R4: Products are summed over 2^E consecutive frames, where E is the exponent. Each output is that sum shifted right arithmetically by E, which rounds toward minus infinity. No result is emitted before the window's last frame.
- R5: A window's results appear on N consecutive cycles with `out_bin` running 0 to N−1. `out_done` is high for exactly one cycle, together with bin N−1.
- R6: Frames in which every bin is at full scale, with every weight at its maximum and E at its maximum, are summed without overflow.
- R7: `cfg_alpha` and `cfg_lexp` are captured when the first frame of a window starts processing. Changes made later within the window affect only the next window.
- R8: A bin with `in_sof` high always becomes bin 0. Any partly received frame is discarded.
- R9: A `cfg_lexp` value above LMAX_LOG2 is treated as LMAX_LOG2.
- R10: After a done pulse the next window starts from cleared accumulators, with no input or control needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input bin is present |
| in_sof | input | 1 | This bin is bin 0 of a frame |
| in_re | input | DW | Bin real part, signed |
| in_im | input | DW | Bin imaginary part, signed |
| cfg_alpha | input | N_LOG2 | Cyclic frequency in bins |
| cfg_lexp | input | LSW | Window length exponent E (L = 2^E) |
| win_we | input | 1 | Window weight write strobe |
| win_addr | input | N_LOG2 | Window weight bin index |
| win_data | input | WW | Window weight, unsigned |
| out_valid | output | 1 | Result present |
| out_bin | output | N_LOG2 | Bin index of the result |
| out_re | output | AW | Averaged real part, signed |
| out_im | output | AW | Averaged imaginary part, signed |
| out_done | output | 1 | Last result of the window |

## Verification
The bench checks wrap-around at alpha = N−1. A design that failed to reduce k−alpha modulo N would pair the low bins with the wrong partner, and their results would differ. It sends extreme-valued frames with the largest weights over the longest window, so an accumulator that is too narrow shows up as a sign-flipped result. It changes alpha and the exponent in the middle of a window, which catches a design that fails to latch them: that design mixes two shifts or two offsets inside one average. It restarts a frame part-way with `in_sof` and sets an out-of-range exponent, which exposes stale bins and a missing clamp. Negative sums check that the average rounds toward minus infinity rather than toward zero.

// File: rtl/scf_pkg.sv
package scf_pkg;
   // width of one weighted conjugate product
   function automatic int prod_width(input int dw, input int ww);
      return 2 * dw + 1 + ww;
   endfunction

   // accumulator width: product plus growth over the longest window
   function automatic int acc_width(input int dw, input int ww, input int lmax);
      return prod_width(dw, ww) + lmax;
   endfunction
endpackage

// File: rtl/scf_frame_buf.sv
module scf_frame_buf #(
   parameter int N_LOG2 = 3,
   parameter int DW     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_valid,
   input  logic                 wr_sof,
   input  logic signed [DW-1:0] wr_re,
   input  logic signed [DW-1:0] wr_im,
   input  logic                 rd_bank,
   input  logic [N_LOG2-1:0]    rd_a_idx,
   input  logic [N_LOG2-1:0]    rd_b_idx,
   output logic signed [DW-1:0] a_re,
   output logic signed [DW-1:0] a_im,
   output logic signed [DW-1:0] b_re,
   output logic signed [DW-1:0] b_im,
   output logic                 frame_done,
   output logic                 done_bank
);
   localparam int N     = 1 << N_LOG2;
   localparam int DEPTH = 2 * N;

   logic signed [DW-1:0] re_q [DEPTH];
   logic signed [DW-1:0] im_q [DEPTH];
   logic [N_LOG2-1:0]    widx_q;
   logic                 wbank_q;
   logic [N_LOG2-1:0]    widx;

   // a start-of-frame marker forces the bin to index 0
   assign widx       = wr_sof ? '0 : widx_q;
   assign frame_done = wr_valid && (widx == {N_LOG2{1'b1}});
   assign done_bank  = wbank_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         widx_q  <= '0;
         wbank_q <= 1'b0;
      end else if (wr_valid) begin
         widx_q <= widx + 1'b1;
         if (frame_done) wbank_q <= ~wbank_q;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_valid) begin
         re_q[{wbank_q, widx}] <= wr_re;
         im_q[{wbank_q, widx}] <= wr_im;
      end
   end

   assign a_re = re_q[{rd_bank, rd_a_idx}];
   assign a_im = im_q[{rd_bank, rd_a_idx}];
   assign b_re = re_q[{rd_bank, rd_b_idx}];
   assign b_im = im_q[{rd_bank, rd_b_idx}];
endmodule

// File: rtl/scf_win_ram.sv
module scf_win_ram #(
   parameter int N_LOG2 = 3,
   parameter int WW     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [N_LOG2-1:0] waddr,
   input  logic [WW-1:0]     wdata,
   input  logic [N_LOG2-1:0] raddr,
   output logic [WW-1:0]     rdata
);
   localparam int N = 1 << N_LOG2;

   logic [WW-1:0] w_q [N];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) w_q[i] <= WW'(1);
      end else if (we) begin
         w_q[waddr] <= wdata;
      end
   end

   assign rdata = w_q[raddr];
endmodule

// File: rtl/scf_xprod.sv
module scf_xprod #(
   parameter int DW = 8,
   parameter int WW = 6,
   localparam int PW = scf_pkg::prod_width(DW, WW)
) (
   input  logic signed [DW-1:0] a_re,
   input  logic signed [DW-1:0] a_im,
   input  logic signed [DW-1:0] b_re,
   input  logic signed [DW-1:0] b_im,
   input  logic [WW-1:0]        w,
   output logic signed [PW-1:0] p_re,
   output logic signed [PW-1:0] p_im
);
   localparam int CW = 2 * DW + 1;

   logic signed [CW-1:0] ar, ai, br, bi, cr, ci;
   logic signed [WW:0]   ws;

   assign ar = CW'(a_re);
   assign ai = CW'(a_im);
   assign br = CW'(b_re);
   assign bi = CW'(b_im);

   // a * conj(b)
   assign cr = ar * br + ai * bi;
   assign ci = ai * br - ar * bi;

   assign ws   = signed'({1'b0, w});
   assign p_re = PW'(cr) * PW'(ws);
   assign p_im = PW'(ci) * PW'(ws);
endmodule

// File: rtl/scf_corr_acc.sv
module scf_corr_acc #(
   parameter int N_LOG2    = 3,
   parameter int DW        = 8,
   parameter int WW        = 6,
   parameter int LMAX_LOG2 = 3,
   localparam int N   = 1 << N_LOG2,
   localparam int PW  = scf_pkg::prod_width(DW, WW),
   localparam int AW  = scf_pkg::acc_width(DW, WW, LMAX_LOG2),
   localparam int LSW = $clog2(LMAX_LOG2 + 2)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 in_sof,
   input  logic signed [DW-1:0] in_re,
   input  logic signed [DW-1:0] in_im,
   input  logic [N_LOG2-1:0]    cfg_alpha,
   input  logic [LSW-1:0]       cfg_lexp,
   input  logic                 win_we,
   input  logic [N_LOG2-1:0]    win_addr,
   input  logic [WW-1:0]        win_data,
   output logic                 out_valid,
   output logic [N_LOG2-1:0]    out_bin,
   output logic signed [AW-1:0] out_re,
   output logic signed [AW-1:0] out_im,
   output logic                 out_done
);
   if (N_LOG2 < 2 || DW < 2 || WW < 1 || LMAX_LOG2 < 1) begin : g_bad_cfg
      $error("scf_corr_acc: parameter out of supported range");
   end

   logic                    proc_q, pbank_q;
   logic [N_LOG2-1:0]       k_q, alpha_q, b_idx;
   logic [LMAX_LOG2-1:0]    fcnt_q, fcnt_nxt;
   logic [LSW-1:0]          lexp_q, lexp_in;
   logic [LMAX_LOG2:0]      fplus, flim;
   logic                    is_last, sweep_end;
   logic                    fb_done, fb_bank;
   logic signed [DW-1:0]    a_re, a_im, b_re, b_im;
   logic [WW-1:0]           w_k;
   logic signed [PW-1:0]    p_re, p_im;
   logic signed [AW-1:0]    sum_re, sum_im;
   logic signed [AW-1:0]    acc_re_w [N];
   logic signed [AW-1:0]    acc_im_w [N];

   assign lexp_in = (cfg_lexp > LSW'(LMAX_LOG2)) ? LSW'(LMAX_LOG2) : cfg_lexp;
   assign b_idx   = k_q - alpha_q;

   scf_frame_buf #(.N_LOG2(N_LOG2), .DW(DW)) u_fbuf (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(in_valid), .wr_sof(in_sof), .wr_re(in_re), .wr_im(in_im),
      .rd_bank(pbank_q), .rd_a_idx(k_q), .rd_b_idx(b_idx),
      .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
      .frame_done(fb_done), .done_bank(fb_bank)
   );

   scf_win_ram #(.N_LOG2(N_LOG2), .WW(WW)) u_win (
      .clk(clk), .rst_n(rst_n),
      .we(win_we), .waddr(win_addr), .wdata(win_data),
      .raddr(k_q), .rdata(w_k)
   );

   scf_xprod #(.DW(DW), .WW(WW)) u_xprod (
      .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .w(w_k),
      .p_re(p_re), .p_im(p_im)
   );

   // window position tracking
   assign fplus     = {1'b0, fcnt_q} + 1'b1;
   assign flim      = (LMAX_LOG2 + 1)'(1) << lexp_q;
   assign is_last   = (fplus == flim);
   assign sweep_end = proc_q && (k_q == {N_LOG2{1'b1}});
   assign fcnt_nxt  = sweep_end ? (is_last ? '0 : fcnt_q + 1'b1) : fcnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         proc_q  <= 1'b0;
         k_q     <= '0;
         pbank_q <= 1'b0;
         fcnt_q  <= '0;
         alpha_q <= '0;
         lexp_q  <= '0;
      end else begin
         fcnt_q <= fcnt_nxt;
         if (fb_done) begin
            proc_q  <= 1'b1;
            k_q     <= '0;
            pbank_q <= fb_bank;
            if (fcnt_nxt == '0) begin
               alpha_q <= cfg_alpha;
               lexp_q  <= lexp_in;
            end
         end else if (sweep_end) begin
            proc_q <= 1'b0;
         end else if (proc_q) begin
            k_q <= k_q + 1'b1;
         end
      end
   end

   // one accumulator pair per bin
   for (genvar g = 0; g < N; g++) begin : g_bin
      logic signed [AW-1:0] acc_re_q, acc_im_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            acc_re_q <= '0;
            acc_im_q <= '0;
         end else if (proc_q && k_q == N_LOG2'(g)) begin
            acc_re_q <= is_last ? '0 : sum_re;
            acc_im_q <= is_last ? '0 : sum_im;
         end
      end
      assign acc_re_w[g] = acc_re_q;
      assign acc_im_w[g] = acc_im_q;
   end

   assign sum_re = acc_re_w[k_q] + AW'(p_re);
   assign sum_im = acc_im_w[k_q] + AW'(p_im);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_done  <= 1'b0;
         out_bin   <= '0;
         out_re    <= '0;
         out_im    <= '0;
      end else begin
         out_valid <= proc_q && is_last;
         out_done  <= sweep_end && is_last;
         out_bin   <= k_q;
         out_re    <= sum_re >>> lexp_q;
         out_im    <= sum_im >>> lexp_q;
      end
   end
endmodule

// File: rtl/scf_corr_acc_chk.sv
module scf_corr_acc_chk #(
   parameter int N_LOG2 = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_valid,
   input logic [N_LOG2-1:0] out_bin,
   input logic              out_done
);
   assert_done_on_last_bin_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> (out_valid && out_bin == {N_LOG2{1'b1}}));

   assert_bins_ascend_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_done) |=> (out_valid && out_bin == $past(out_bin) + 1'b1));

   assert_window_starts_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (out_bin == '0));

   assert_done_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |=> !out_done);
endmodule

bind scf_corr_acc scf_corr_acc_chk #(.N_LOG2(N_LOG2)) u_chk (
   .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_bin(out_bin), .out_done(out_done)
);

// File: tb/scf_corr_acc_tb.sv
module scf_corr_acc_tb;
   localparam int N_LOG2 = 3, DW = 8, WW = 6, LMAX = 3;
   localparam int N   = 1 << N_LOG2;
   localparam int AW  = 2 * DW + 1 + WW + LMAX;
   localparam int LSW = $clog2(LMAX + 2);

   logic clk = 0, rst_n = 0;
   logic in_valid = 0, in_sof = 0;
   logic signed [DW-1:0] in_re = 0, in_im = 0;
   logic [N_LOG2-1:0] cfg_alpha = 0;
   logic [LSW-1:0] cfg_lexp = 0;
   logic win_we = 0;
   logic [N_LOG2-1:0] win_addr = 0;
   logic [WW-1:0] win_data = 0;
   logic out_valid, out_done;
   logic [N_LOG2-1:0] out_bin;
   logic signed [AW-1:0] out_re, out_im;

   always #10 clk = ~clk;

   scf_corr_acc #(.N_LOG2(N_LOG2), .DW(DW), .WW(WW), .LMAX_LOG2(LMAX)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_re(in_re), .in_im(in_im), .cfg_alpha(cfg_alpha), .cfg_lexp(cfg_lexp),
      .win_we(win_we), .win_addr(win_addr), .win_data(win_data),
      .out_valid(out_valid), .out_bin(out_bin), .out_re(out_re), .out_im(out_im),
      .out_done(out_done)
   );

   int n_cmp = 0, n_bad = 0;
   int fr_re [8][N];
   int fr_im [8][N];
   int win_b [N];
   longint got_re [N];
   longint got_im [N];
   int got_n = 0, done_n = 0;
   int unsigned seed = 32'h1234_5678;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int rnd8();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'((seed >> 16) & 32'hff) - 128;
   endfunction

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         got_re[out_bin] = longint'(out_re);
         got_im[out_bin] = longint'(out_im);
         got_n++;
         if (out_done) done_n++;
      end
   end

   task automatic fill_random();
      for (int f = 0; f < 8; f++)
         for (int k = 0; k < N; k++) begin
            fr_re[f][k] = rnd8();
            fr_im[f][k] = rnd8();
         end
   endtask

   task automatic win_write(input int a, input int d);
      @(negedge clk);
      win_we = 1; win_addr = N_LOG2'(a); win_data = WW'(d);
      win_b[a] = d;
      @(negedge clk);
      win_we = 0;
   endtask

   // frames first .. first+count-1 with no idle cycles between them
   task automatic send_frames(input int first, input int count);
      for (int f = first; f < first + count; f++)
         for (int k = 0; k < N; k++) begin
            @(negedge clk);
            in_valid = 1; in_sof = (k == 0);
            in_re = DW'(fr_re[f][k]); in_im = DW'(fr_im[f][k]);
         end
      @(negedge clk);
      in_valid = 0; in_sof = 0;
   endtask

   task automatic clear_got();
      got_n = 0; done_n = 0;
      for (int k = 0; k < N; k++) begin got_re[k] = 0; got_im[k] = 0; end
   endtask

   task automatic wait_done();
      for (int i = 0; i < 100 && done_n == 0; i++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic compare(input int first, input int count, input int alpha,
                          input int lexp, input string req);
      check(got_n == N, {req, " result count"}, got_n, N);
      check(done_n == 1, {req, " done count"}, done_n, 1);
      for (int k = 0; k < N; k++) begin
         longint sr = 0, si = 0;
         int j = (k - alpha + N) % N;
         for (int f = first; f < first + count; f++) begin
            longint xr = fr_re[f][k], xi = fr_im[f][k];
            longint yr = fr_re[f][j], yi = fr_im[f][j];
            sr += (xr * yr + xi * yi) * win_b[k];
            si += (xi * yr - xr * yi) * win_b[k];
         end
         sr = sr >>> lexp;
         si = si >>> lexp;
         check(got_re[k] == sr, {req, " real"}, got_re[k], sr);
         check(got_im[k] == si, {req, " imag"}, got_im[k], si);
      end
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < N; k++) win_b[k] = 1;
      repeat (3) @(negedge clk);
      check(out_valid == 0 && out_done == 0, "R1 in reset", out_valid, 0);
      rst_n = 1;
      repeat (4) @(negedge clk);
      check(out_valid == 0 && out_done == 0, "R1 after reset", out_valid, 0);

      fill_random();
      // R3 R2: default unity weights, alpha 0, single frame
      clear_got(); cfg_alpha = 0; cfg_lexp = 0;
      send_frames(0, 1); wait_done();
      compare(0, 1, 0, 0, "R3 unity window");

      // R4: loaded weights, alpha 3, L=4; nothing before the fourth frame
      for (int k = 0; k < N; k++) win_write(k, (k * 7 + 3) % 64);
      clear_got(); cfg_alpha = 3; cfg_lexp = 2;
      send_frames(1, 3);
      repeat (N + 4) @(negedge clk);
      check(got_n == 0, "R4 no early output", got_n, 0);
      send_frames(4, 1); wait_done();
      compare(1, 4, 3, 2, "R4 average of four");

      // R2: wrap with alpha = N-1
      clear_got(); cfg_alpha = N_LOG2'(N - 1); cfg_lexp = 1;
      send_frames(5, 2); wait_done();
      compare(5, 2, N - 1, 1, "R2 wrap");

      // R6: full-scale extremes, max weight, longest window
      for (int k = 0; k < N; k++) win_write(k, 63);
      for (int f = 0; f < 8; f++)
         for (int k = 0; k < N; k++) begin
            fr_re[f][k] = (k % 2 == 0) ? -128 : 127;
            fr_im[f][k] = (k % 2 == 0) ? 127 : -128;
         end
      clear_got(); cfg_alpha = 1; cfg_lexp = 3;
      send_frames(0, 8); wait_done();
      compare(0, 8, 1, 3, "R6 full scale");
      for (int k = 0; k < N; k++) fr_re[0][k] = -128;
      for (int k = 0; k < N; k++) fr_im[0][k] = -128;
      clear_got(); cfg_alpha = 0; cfg_lexp = 0;
      send_frames(0, 1); wait_done();
      compare(0, 1, 0, 0, "R6 most negative");

      // R7 and R10: mid-window config change, then a fresh window
      fill_random();
      for (int k = 0; k < N; k++) win_write(k, (k * 5 + 1) % 64);
      clear_got(); cfg_alpha = 1; cfg_lexp = 1;
      send_frames(0, 1);
      repeat (3) @(negedge clk);
      cfg_alpha = 5; cfg_lexp = 0;
      send_frames(1, 1); wait_done();
      compare(0, 2, 1, 1, "R7 latched config");
      clear_got();
      send_frames(2, 1); wait_done();
      compare(2, 1, 5, 0, "R10 next window");

      // R8: partial frame abandoned by a new start marker
      clear_got(); cfg_alpha = 2; cfg_lexp = 0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         in_valid = 1; in_sof = (k == 0);
         in_re = DW'(fr_re[3][k]); in_im = DW'(fr_im[3][k]);
      end
      send_frames(4, 1); wait_done();
      compare(4, 1, 2, 0, "R8 resync");

      // R9: exponent above the maximum is clamped
      clear_got(); cfg_alpha = 6; cfg_lexp = LSW'(7);
      send_frames(0, 8); wait_done();
      compare(0, 8, 6, 3, "R9 clamp");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule